// File: doc/BRIEF.md
# Memory-Based Time-Slot Interchanger

The block reorders the byte slots of a repeating TDM frame on one parallel byte stream. Each arriving byte is stored at the address of its slot. One frame later the byte is read back in the position chosen by a programmable connection table. Every accepted slot costs one memory write and one memory read, and the two accesses fall in different banks of a two-bank frame store. The frame being written fills one bank while the frame written before it is read out of the other. The roles of the two banks swap at each input frame start.

The input stream gives one byte per cycle in which `in_valid` is high. `in_fsync` marks the beat that carries slot 0, and cycles with no valid byte may fall anywhere. Output slot k appears one cycle after input slot k of the next frame, so the output frame trails the input frame by exactly one frame. Each output slot has a table entry that names a source slot or marks the slot idle. An idle slot, and a slot whose source index is out of range, sends a fixed idle byte. Table writes go to a shadow copy. The copy is taken into use only at the next frame start, so no frame is ever switched with a half-updated table.

Top module: `tsi_interchanger`

## Requirements
- R1: While reset is active and in the cycle after it, `out_valid` and `out_fsync` are 0 and `out_data` is 0xFF.
- R2: No output beat is produced until one full frame has been stored. `out_valid` stays 0 up to and including the beat that carries the first frame start.
- R3: Output beats come in input slot order, one cycle after the matching input beat of the following frame. Output slot k carries the byte that arrived in slot `src[k]` of the previous frame.
- R4: Once one full frame has been stored, every valid input beat produces `out_valid` in the next cycle. `out_fsync` is high in the cycle after an input frame-start beat, and only then.
- R5: An output slot whose table entry has its idle flag set (`cfg_idle`=1) sends 0xFF.
- R6: An output slot whose source index is 24 or more sends 0xFF.
- R7: A table write reaches the output only in the frame that begins at the next input frame start after the write. A write in the same cycle as a frame-start beat waits for the frame start after that one.
- R8: After reset, the table maps every output slot k to source slot k and has no idle entries.
- R9: A cycle with `in_valid` low does not advance the slot count. In the next cycle `out_valid` is 0 and `out_data` holds its value.
- R10: Valid beats that arrive before the first frame start are discarded and produce no output.
- R11: Any mapping is allowed, including a reversal and several output slots reading the same source slot in one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present this cycle |
| in_fsync | input | 1 | Input beat is slot 0 of a frame (used only with in_valid) |
| in_data | input | 8 | Input slot byte |
| cfg_we | input | 1 | Write one table entry |
| cfg_slot | input | 5 | Output slot whose entry is written (writes to 24 or more are ignored) |
| cfg_src | input | 5 | Source slot index for that output slot |
| cfg_idle | input | 1 | Mark that output slot idle |
| out_valid | output | 1 | Output byte present this cycle |
| out_fsync | output | 1 | Output beat is slot 0 of a frame |
| out_data | output | 8 | Output slot byte |

## Verification
The assertions assume that the input is well framed. Once the first frame start has been seen, no frame carries more than 24 valid beats before the next frame start, and one of the checks watches this input condition. The stimulus keeps to it by sending every frame as exactly 24 beats, each starting with a frame-start beat. Idle cycles are inserted only between beats of a frame. Stray beats are sent only before the first frame start, where the block is specified to discard them. The checks on primed output, silence during gaps and frame-start alignment depend on that framing.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   localparam int TSI_DEF_SLOTS = 24;
   localparam int TSI_DEF_DW    = 8;

   // which of the two frame banks a beat addresses
   typedef enum logic {
      BANK_LO = 1'b0,
      BANK_HI = 1'b1
   } tsi_bank_e;

   function automatic tsi_bank_e tsi_other(input tsi_bank_e b);
      return (b == BANK_LO) ? BANK_HI : BANK_LO;
   endfunction
endpackage

// File: rtl/tsi_slot_tracker.sv
module tsi_slot_tracker
   import tsi_pkg::*;
#(
   parameter int SLOTS = TSI_DEF_SLOTS,
   parameter int IDX_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_fsync,
   output logic             wr_en,
   output logic [IDX_W-1:0] slot,
   output tsi_bank_e        wr_bank,
   output tsi_bank_e        rd_bank,
   output logic             swap,
   output logic             emit
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

   logic             seen_q;
   logic             primed_q;
   logic [IDX_W-1:0] cnt_q;
   tsi_bank_e        bank_q;

   assign swap    = in_valid & in_fsync;
   assign slot    = in_fsync ? '0 : cnt_q;
   assign wr_bank = swap ? tsi_other(bank_q) : bank_q;
   assign rd_bank = tsi_other(wr_bank);
   assign wr_en   = in_valid & (in_fsync | seen_q);
   assign emit    = in_valid & (primed_q | (in_fsync & seen_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q   <= 1'b0;
         primed_q <= 1'b0;
         cnt_q    <= '0;
         bank_q   <= BANK_LO;
      end else begin
         if (swap) begin
            seen_q <= 1'b1;
            bank_q <= tsi_other(bank_q);
            if (seen_q) primed_q <= 1'b1;
         end
         if (wr_en) cnt_q <= (slot == LAST) ? '0 : slot + 1'b1;
      end
   end
endmodule

// File: rtl/tsi_frame_store.sv
module tsi_frame_store
   import tsi_pkg::*;
#(
   parameter int SLOTS = TSI_DEF_SLOTS,
   parameter int DW    = TSI_DEF_DW,
   parameter int IDX_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  tsi_bank_e        wr_bank,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  tsi_bank_e        rd_bank,
   input  logic [IDX_W-1:0] rd_addr,
   output logic [DW-1:0]    rd_data
);
   localparam int NBANK = 2;

   logic [NBANK-1:0][DW-1:0] bank_word;
   logic [IDX_W-1:0]         rd_idx;

   // a table that fills the whole index space needs no range guard
   if (SLOTS == (1 << IDX_W)) begin : g_full
      assign rd_idx = rd_addr;
   end else begin : g_guard
      localparam logic [IDX_W:0] NS = (IDX_W + 1)'(SLOTS);
      assign rd_idx = ({1'b0, rd_addr} < NS) ? rd_addr : '0;
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [DW-1:0] mem [SLOTS];
      always_ff @(posedge clk) begin
         if (wr_en && wr_bank == tsi_bank_e'(b)) mem[wr_addr] <= wr_data;
      end
      assign bank_word[b] = mem[rd_idx];
   end

   assign rd_data = bank_word[rd_bank];
endmodule

// File: rtl/tsi_conn_map.sv
module tsi_conn_map #(
   parameter int SLOTS = 24,
   parameter int IDX_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [IDX_W-1:0] cfg_slot,
   input  logic [IDX_W-1:0] cfg_src,
   input  logic             cfg_idle,
   input  logic             swap,
   input  logic [IDX_W-1:0] lk_slot,
   output logic [IDX_W-1:0] lk_src,
   output logic             lk_use
);
   localparam logic [IDX_W:0] NS = (IDX_W + 1)'(SLOTS);

   logic [IDX_W-1:0] sh_src  [SLOTS];
   logic             sh_idle [SLOTS];
   logic [IDX_W-1:0] act_src [SLOTS];
   logic             act_idle[SLOTS];
   logic             cfg_ok;
   logic             ent_idle;

   assign cfg_ok = cfg_we & ({1'b0, cfg_slot} < NS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < SLOTS; k++) begin
            sh_src[k]   <= IDX_W'(k);
            sh_idle[k]  <= 1'b0;
            act_src[k]  <= IDX_W'(k);
            act_idle[k] <= 1'b0;
         end
      end else begin
         for (int k = 0; k < SLOTS; k++) begin
            if (cfg_ok && cfg_slot == IDX_W'(k)) begin
               sh_src[k]  <= cfg_src;
               sh_idle[k] <= cfg_idle;
            end
            if (swap) begin
               act_src[k]  <= sh_src[k];
               act_idle[k] <= sh_idle[k];
            end
         end
      end
   end

   // on the frame-start beat the new frame already uses the shadow copy
   always_comb begin
      if (swap) begin
         lk_src   = sh_src[0];
         ent_idle = sh_idle[0];
      end else begin
         lk_src   = act_src[lk_slot];
         ent_idle = act_idle[lk_slot];
      end
   end

   assign lk_use = ~ent_idle & ({1'b0, lk_src} < NS);
endmodule

// File: rtl/tsi_interchanger.sv
module tsi_interchanger
   import tsi_pkg::*;
#(
   parameter int            SLOTS     = TSI_DEF_SLOTS,
   parameter int            DW        = TSI_DEF_DW,
   parameter int            IDX_W     = $clog2(SLOTS),
   parameter logic [DW-1:0] IDLE_BYTE = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_fsync,
   input  logic [DW-1:0]    in_data,
   input  logic             cfg_we,
   input  logic [IDX_W-1:0] cfg_slot,
   input  logic [IDX_W-1:0] cfg_src,
   input  logic             cfg_idle,
   output logic             out_valid,
   output logic             out_fsync,
   output logic [DW-1:0]    out_data
);
   if (SLOTS < 2) begin : g_bad_slots
      $error("tsi_interchanger: SLOTS must be at least 2");
   end
   if (IDX_W < $clog2(SLOTS)) begin : g_bad_idx
      $error("tsi_interchanger: IDX_W too narrow for SLOTS");
   end
   if (DW < 1) begin : g_bad_dw
      $error("tsi_interchanger: DW must be positive");
   end

   logic             wr_en;
   logic [IDX_W-1:0] slot;
   tsi_bank_e        wr_bank;
   tsi_bank_e        rd_bank;
   logic             swap;
   logic             emit;
   logic [IDX_W-1:0] src;
   logic             use_src;
   logic [DW-1:0]    rd_data;

   tsi_slot_tracker #(.SLOTS(SLOTS), .IDX_W(IDX_W)) trk_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fsync(in_fsync),
      .wr_en(wr_en), .slot(slot), .wr_bank(wr_bank), .rd_bank(rd_bank),
      .swap(swap), .emit(emit)
   );

   tsi_conn_map #(.SLOTS(SLOTS), .IDX_W(IDX_W)) map_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
      .cfg_src(cfg_src), .cfg_idle(cfg_idle), .swap(swap),
      .lk_slot(slot), .lk_src(src), .lk_use(use_src)
   );

   tsi_frame_store #(.SLOTS(SLOTS), .DW(DW), .IDX_W(IDX_W)) store_i (
      .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(slot),
      .wr_data(in_data), .rd_bank(rd_bank), .rd_addr(src), .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_fsync <= 1'b0;
         out_data  <= IDLE_BYTE;
      end else begin
         out_valid <= emit;
         out_fsync <= emit & in_fsync;
         if (emit) out_data <= use_src ? rd_data : IDLE_BYTE;
      end
   end
endmodule

// File: rtl/tsi_interchanger_chk.sv
module tsi_interchanger_chk #(
   parameter int SLOTS = 24,
   parameter int DW    = 8,
   parameter int IDX_W = $clog2(SLOTS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_fsync,
   input logic          out_valid,
   input logic          out_fsync,
   input logic [DW-1:0] out_data
);
   localparam logic [IDX_W:0] NS = (IDX_W + 1)'(SLOTS);

   logic [1:0]     fs_seen;
   logic [IDX_W:0] beats;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_seen <= '0;
         beats   <= '0;
      end else if (in_valid) begin
         if (in_fsync) begin
            if (fs_seen != 2'd2) fs_seen <= fs_seen + 2'd1;
            beats <= (IDX_W + 1)'(1);
         end else if (fs_seen != 2'd0) begin
            beats <= beats + 1'b1;
         end
      end
   end

   // R2, R10: silent until a full frame is stored
   a_r2_silent_until_primed: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_seen == 2'd0 || (fs_seen == 2'd1 && !(in_valid && in_fsync))) |=> !out_valid);

   // R4: every beat after priming produces output
   a_r4_emit_when_primed: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fs_seen == 2'd2) |=> out_valid);

   // R4: output frame start follows an input frame-start beat
   a_r4_fsync_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      out_fsync |-> (out_valid && $past(in_valid && in_fsync)));

   // R9: a gap cycle yields no output and holds the data
   a_r9_gap_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data)));

   // R3: input framing assumption, no frame longer than SLOTS beats
   a_r3_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_fsync && fs_seen != 2'd0) |-> (beats < NS));
endmodule

bind tsi_interchanger tsi_interchanger_chk #(
   .SLOTS(SLOTS), .DW(DW), .IDX_W(IDX_W)
) chk_i (.*);

// File: tb/tsi_interchanger_tb_top.sv
module tsi_interchanger_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SLOTS      = 24;
   localparam int DW         = 8;
   localparam int IW         = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_fsync = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_slot = '0;
   logic [IW-1:0] cfg_src = '0;
   logic          cfg_idle = 1'b0;
   logic          out_valid;
   logic          out_fsync;
   logic [DW-1:0] out_data;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tsi_interchanger dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fsync(in_fsync),
      .in_data(in_data), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
      .cfg_src(cfg_src), .cfg_idle(cfg_idle), .out_valid(out_valid),
      .out_fsync(out_fsync), .out_data(out_data)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int n_out    = 0;
   bit done     = 1'b0;

   logic [DW-1:0] exp_d_q[$];
   logic          exp_f_q[$];
   string         exp_r_q[$];

   // reference model state
   logic [DW-1:0] cur_m  [SLOTS];
   logic [DW-1:0] prev_m [SLOTS];
   logic [IW-1:0] sh_src [SLOTS];
   logic          sh_idle[SLOTS];
   logic [IW-1:0] act_src[SLOTS];
   logic          act_idle[SLOTS];
   int            frames = 0;
   int            slot_m = 0;
   string         tag    = "";

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every output beat
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         n_out++;
         if (exp_d_q.size() == 0) begin
            check(1'b0, "R2 R10", "unexpected output beat", int'(out_data), -1);
         end else begin
            logic [DW-1:0] ed;
            logic          ef;
            string         er;
            ed = exp_d_q.pop_front();
            ef = exp_f_q.pop_front();
            er = exp_r_q.pop_front();
            check(out_data == ed, er, "output byte", int'(out_data), int'(ed));
            check(out_fsync == ef, "R4", "output frame start", int'(out_fsync), int'(ef));
         end
      end
   end

   task automatic beat(input bit fs, input logic [DW-1:0] d, input bit cw,
                       input int ca, input int cs, input bit ci);
      logic [DW-1:0] e;
      in_valid = 1'b1;
      in_fsync = fs;
      in_data  = d;
      cfg_we   = cw;
      cfg_slot = IW'(ca);
      cfg_src  = IW'(cs);
      cfg_idle = ci;
      if (fs) begin
         frames++;
         prev_m = cur_m;
         act_src = sh_src;
         act_idle = sh_idle;
         slot_m = 0;
      end else if (frames > 0) begin
         slot_m++;
      end
      if (frames >= 2) begin
         if (act_idle[slot_m] || act_src[slot_m] >= IW'(SLOTS)) e = 8'hFF;
         else e = prev_m[act_src[slot_m]];
         exp_d_q.push_back(e);
         exp_f_q.push_back(fs);
         exp_r_q.push_back(tag);
      end
      if (frames >= 1) cur_m[slot_m] = d;
      if (cw && ca < SLOTS) begin
         sh_src[ca]  = IW'(cs);
         sh_idle[ca] = ci;
      end
      @(negedge clk);
   endtask

   task automatic gap(input int n);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b0;
         in_fsync = 1'b0;
         cfg_we   = 1'b0;
         @(negedge clk);
         check(out_valid == 1'b0, "R9", "out_valid in gap", int'(out_valid), 0);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int f, input int s);
      return {1'b0, 7'(f * 53 + s * 7 + 1)};
   endfunction

   task automatic run_frame(input int f, input int mode);
      for (int s = 0; s < SLOTS; s++) begin
         bit cw = 1'b0;
         int ca = 0;
         int cs = 0;
         bit ci = 1'b0;
         case (mode)
            1: begin cw = 1'b1; ca = s; cs = SLOTS - 1 - s; end
            2: begin
               cw = 1'b1; ca = s; cs = (s * 5) % SLOTS;
               if (s >= 20) cs = 0;        // R11 broadcast
               if (s == 2) ci = 1'b1;      // R5 idle entry
               if (s == 7) cs = 30;        // R6 out-of-range source
            end
            3: begin
               if (s == 0)  begin cw = 1'b1; ca = 0; cs = 0; ci = 1'b1; end
               if (s == 12) begin cw = 1'b1; ca = 5; cs = 1; end
            end
            default: ;
         endcase
         beat(s == 0, pat(f, s), cw, ca, cs, ci);
         if (mode == 3 && (s % 5) == 4) gap(2);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R3: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int k = 0; k < SLOTS; k++) begin
         sh_src[k] = IW'(k);   // R8 identity after reset
         sh_idle[k] = 1'b0;
         cur_m[k] = '0;
      end
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      check(out_fsync == 1'b0, "R1", "out_fsync in reset", int'(out_fsync), 0);
      check(out_data == 8'hFF, "R1", "out_data in reset", int'(out_data), 'hFF);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
      check(out_data == 8'hFF, "R1", "out_data after reset", int'(out_data), 'hFF);

      // R10: stray beats before the first frame start
      for (int i = 0; i < 3; i++) beat(1'b0, 8'hA0 + 8'(i), 1'b0, 0, 0, 1'b0);
      // frame 0: stored, nothing sent (R2)
      tag = "R2";
      run_frame(0, 0);
      check(n_out == 0, "R2 R10", "output beats before priming", n_out, 0);
      tag = "R8 R7 R4";
      run_frame(1, 1);    // identity output, reversal written mid-frame
      tag = "R3 R11";
      run_frame(2, 2);    // reversed output, mixed map written
      tag = "R5 R6 R11 R9";
      run_frame(3, 3);    // gaps, write on frame-start beat and mid-frame
      tag = "R7";
      run_frame(4, 0);
      tag = "R3";
      run_frame(5, 0);
      gap(3);
      check(exp_d_q.size() == 0, "R3", "pending expected beats", exp_d_q.size(), 0);
      finish_run();
   end
endmodule